// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor

This block adds or subtracts two N-bit operands with one shared ripple-carry chain of full-adder cells. With the operation select low it forms A + B. With it high it forms A - B: every bit of B is inverted on its way into the chain and a carry of one enters through the least significant cell's carry input, so no second datapath and no separate incrementer exist. The same bit pattern serves unsigned and two's complement callers. The raw carry out of the top column is reported for unsigned use. A signed overflow flag comes from the signs of the two values that enter the chain and the sign of the sum.

The result, carry and overflow are captured in one output register, so each answer appears one clock after its operands. A second result port gives the registered sum widened to a larger parameterised width by copying its sign bit into every added position. A caller that treats the operands as unsigned reads the carry. A signed caller reads the overflow flag and ignores the carry.

Top module: `addsub_core`

## Requirements
- R1: With `sub_i` = 0 sampled at a rising edge, `res_o` after that edge equals (A + B) mod 2^N.
- R2: With `sub_i` = 1 sampled at a rising edge, `res_o` after that edge equals (A - B) mod 2^N, formed as A + (bitwise NOT B) + 1.
- R3: In an addition, `cout_o` is 1 exactly when A + B, taken as unsigned values, is 2^N or more.
- R4: In a subtraction, `cout_o` is the carry out of A + NOT B + 1, which is 1 exactly when A >= B as unsigned values (1 means no borrow).
- R5: In an addition, `ovf_o` is 1 exactly when A and B have the same sign bit (bit N-1) and the result's sign bit differs from it. Operands of opposite sign never raise it.
- R6: In a subtraction, `ovf_o` applies the same sign rule to A and NOT B, so it is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's. Operands of equal sign never raise it.
- R7: The signed range is -2^(N-1) to 2^(N-1)-1. With N = 8: 127 + 1, -128 + -1, 0 - (-128) and -128 - 1 overflow. -128 - (-128) = 0 and -1 - 127 = -128 do not.
- R8: `res_ext_o` always equals `res_o` with its bit N-1 copied into bits EW-1 down to N. For example, 4-bit 1010 widens to 11111010, and both read as -6.
- R9: While `rst_n` is low, `res_o`, `cout_o`, `ovf_o` and `res_ext_o` are all zero. This holds from the first rising edge with reset low, or at once when reset goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | W | Operand A (augend or minuend) |
| opb_i | input | W | Operand B (addend or subtrahend) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| res_o | output | W | Registered N-bit result |
| cout_o | output | 1 | Registered raw carry out of the top column |
| ovf_o | output | 1 | Registered signed overflow flag |
| res_ext_o | output | EW | Registered result, sign-extended to EW bits |

## Verification
Every output register is reloaded on every clock, so no wrong value can persist. A broken carry link in the chain shows as a wrong result bit, and often a wrong carry, one cycle after any operand pair whose carry runs through that column. This is why the vectors include long carry runs such as all-ones plus one. A missing inversion or a missing injected carry in subtraction shows at once as a result off by one or more. A wrong sign rule is caught only by the boundary pairs at the asymmetric range ends, so those are applied in both directions for both operations.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // odd parity of the three inputs gives the sum; any two set give the carry
    assign s_o = x_i ^ y_i ^ c_i;
    assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] carry;

    assign carry[0] = cin_i;

    // carries move from column 0 upward, one cell at a time
    for (genvar k = 0; k < W; k++) begin : g_col
        fa_cell u_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry[k]),
            .s_o (sum_o[k]),
            .c_o (carry[k+1])
        );
    end

    assign cout_o = carry[W];
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect (
    input  logic sx_i,
    input  logic sy_i,
    input  logic ss_i,
    output logic ovf_o
);
    // same-sign inputs whose sum changes sign have left the signed range
    assign ovf_o = (sx_i == sy_i) && (ss_i != sx_i);
endmodule

// File: rtl/sext_unit.sv
module sext_unit #(
    parameter int W  = 8,
    parameter int EW = 16
) (
    input  logic [W-1:0]  val_i,
    output logic [EW-1:0] ext_o
);
    localparam int PAD = EW - W;

    if (PAD > 0) begin : g_pad
        assign ext_o = {{PAD{val_i[W-1]}}, val_i};
    end else begin : g_nopad
        assign ext_o = val_i[EW-1:0];
    end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W  = 8,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic          sub_i,
    output logic [W-1:0]  res_o,
    output logic          cout_o,
    output logic          ovf_o,
    output logic [EW-1:0] res_ext_o
);
    import addsub_pkg::*;

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
        logic         ovf;
    } out_t;

    op_e          op;
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W-1:0] chain_sum;
    logic         chain_cout;
    logic         chain_ovf;
    out_t         out_d;
    out_t         out_q;

    assign op = op_e'(sub_i);

    // subtract: invert B and inject one as the first column's carry
    always_comb begin
        b_eff = (op == OP_SUB) ? ~opb_i : opb_i;
        cin   = (op == OP_SUB);
    end

    ripple_chain #(.W(W)) u_chain (
        .x_i    (opa_i),
        .y_i    (b_eff),
        .cin_i  (cin),
        .sum_o  (chain_sum),
        .cout_o (chain_cout)
    );

    // the sign rule sees the operands exactly as they enter the chain
    ovf_detect u_ovf (
        .sx_i  (opa_i[MSB]),
        .sy_i  (b_eff[MSB]),
        .ss_i  (chain_sum[MSB]),
        .ovf_o (chain_ovf)
    );

    always_comb begin
        out_d      = out_q;
        out_d.res  = chain_sum;
        out_d.cout = chain_cout;
        out_d.ovf  = chain_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o  = out_q.res;
    assign cout_o = out_q.cout;
    assign ovf_o  = out_q.ovf;

    sext_unit #(.W(W), .EW(EW)) u_sext (
        .val_i (out_q.res),
        .ext_o (res_ext_o)
    );
endmodule

// File: rtl/addsub_core_chk.sv
module addsub_core_chk #(
    parameter int W  = 8,
    parameter int EW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  opa_i,
    input logic [W-1:0]  opb_i,
    input logic          sub_i,
    input logic [W-1:0]  res_o,
    input logic          cout_o,
    input logic          ovf_o,
    input logic [EW-1:0] res_ext_o
);
    logic [W:0] add_w;
    logic [W:0] sub_w;
    logic       a_ge_b;

    always_comb begin
        add_w  = {1'b0, opa_i} + {1'b0, opb_i};
        sub_w  = {1'b0, opa_i} - {1'b0, opb_i};
        a_ge_b = (opa_i >= opb_i);
    end

    a_r1_add_res: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_i |=> res_o == $past(add_w[W-1:0]));

    a_r2_sub_res: assert property (@(posedge clk) disable iff (!rst_n)
        sub_i |=> res_o == $past(sub_w[W-1:0]));

    a_r3_add_cout: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_i |=> cout_o == $past(add_w[W]));

    a_r4_sub_cout: assert property (@(posedge clk) disable iff (!rst_n)
        sub_i |=> cout_o == $past(a_ge_b));

    a_r5_mixed_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_i && (opa_i[W-1] != opb_i[W-1])) |=> !ovf_o);

    a_r6_same_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_i && (opa_i[W-1] == opb_i[W-1])) |=> !ovf_o);

    a_r8_ext_sign: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(res_ext_o) == $signed(res_o));

    a_r9_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !cout_o && !ovf_o && res_ext_o == '0));
endmodule

bind addsub_core addsub_core_chk #(.W(W), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .sub_i     (sub_i),
    .res_o     (res_o),
    .cout_o    (cout_o),
    .ovf_o     (ovf_o),
    .res_ext_o (res_ext_o)
);

// File: tb/addsub_core_test.sv
module addsub_core_test;
    localparam int W      = 8;
    localparam int EW     = 16;
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic          sub = 1'b0;
    logic [W-1:0]  res;
    logic          cout;
    logic          ovf;
    logic [EW-1:0] rext;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected values, one entry per applied operand pair
    int    q_res[$];
    int    q_cout[$];
    int    q_ovf[$];
    int    q_sub[$];
    string q_otag[$];

    addsub_core #(.W(W), .EW(EW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .opa_i     (opa),
        .opb_i     (opb),
        .sub_i     (sub),
        .res_o     (res),
        .cout_o    (cout),
        .ovf_o     (ovf),
        .res_ext_o (rext)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int to_signed(input int u);
        return (u >= (1 << (W-1))) ? u - (1 << W) : u;
    endfunction

    task automatic compare_head();
        int    er, ec, eo, es, sv;
        string ot;
        longint ee;
        if (q_res.size() == 0) return;
        er = q_res.pop_front();
        ec = q_cout.pop_front();
        eo = q_ovf.pop_front();
        es = q_sub.pop_front();
        ot = q_otag.pop_front();
        sv = to_signed(er);
        ee = longint'(sv) & ((longint'(1) << EW) - 1);
        check(es ? "R2 result" : "R1 result", res, er);
        check(es ? "R4 carry" : "R3 carry", cout, ec);
        check(ot, ovf, eo);
        check("R8 extension", rext, ee);
    endtask

    task automatic apply(input int a, input int b, input bit s, input string otag = "");
        int sa, sb, full, ua, ub, eov;
        @(negedge clk);
        compare_head();
        ua = a & ((1 << W) - 1);
        ub = b & ((1 << W) - 1);
        sa = to_signed(ua);
        sb = to_signed(ub);
        full = s ? sa - sb : sa + sb;
        eov = (full > (1 << (W-1)) - 1 || full < -(1 << (W-1))) ? 1 : 0;
        opa = ua[W-1:0];
        opb = ub[W-1:0];
        sub = s;
        q_res.push_back(s ? ((ua - ub) & ((1 << W) - 1)) : ((ua + ub) & ((1 << W) - 1)));
        q_cout.push_back(s ? int'(ua >= ub) : int'((ua + ub) >> W));
        q_ovf.push_back(eov);
        q_sub.push_back(int'(s));
        q_otag.push_back(otag != "" ? otag : (s ? "R6 overflow" : "R5 overflow"));
    endtask

    task automatic flush();
        @(negedge clk);
        compare_head();
    endtask

    task automatic check_reset_zero();
        check("R9 reset result", res, 0);
        check("R9 reset carry", cout, 0);
        check("R9 reset ovf", ovf, 0);
        check("R9 reset ext", rext, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        opa = 8'hA5;
        opb = 8'h5A;
        sub = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_zero();
        rst_n = 1'b1;

        // R1 / R3 carry chains
        apply(8'h06, 8'h0F, 1'b0);
        apply(8'hFF, 8'h01, 1'b0);
        apply(8'hFF, 8'hFF, 1'b0);
        apply(8'h00, 8'h00, 1'b0);
        // R2 / R4 borrow behaviour
        apply(8'h33, 8'h16, 1'b1);
        apply(8'h16, 8'h33, 1'b1);
        apply(8'h5A, 8'h5A, 1'b1);
        apply(8'h00, 8'hFF, 1'b1);
        // R5 mixed signs never overflow
        apply(8'h7F, 8'h80, 1'b0);
        apply(8'h01, 8'hFF, 1'b0);
        // R6 equal signs never overflow
        apply(8'h80, 8'hFF, 1'b1);
        apply(8'h7F, 8'h00, 1'b1);
        // R7 range edges
        apply(127, 1, 1'b0, "R7 ovf 127+1");
        apply(8'h80, 8'hFF, 1'b0, "R7 ovf -128+-1");
        apply(0, 8'h80, 1'b1, "R7 ovf 0-(-128)");
        apply(8'h80, 1, 1'b1, "R7 ovf -128-1");
        apply(8'h80, 8'h80, 1'b1, "R7 ovf -128-(-128)");
        apply(8'hFF, 127, 1'b1, "R7 ovf -1-127");
        apply(8'h80, 8'h80, 1'b0, "R7 ovf -128+-128");
        // R8 negative results widen with ones
        apply(8'h02, 8'h08, 1'b1);
        apply(8'hC0, 8'h01, 1'b0);
        // sweep of mixed patterns
        for (int i = 0; i < 300; i++) begin
            apply((i * 37 + 11) & 8'hFF, (i * 91 + 200) & 8'hFF, i[0]);
        end
        flush();

        // R9 reset in the middle of traffic
        @(negedge clk);
        opa = 8'h7F;
        opb = 8'h7F;
        sub = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_zero();
        @(negedge clk);
        check_reset_zero();
        rst_n = 1'b1;
        apply(8'h40, 8'h40, 1'b0, "R5 overflow after reset");
        flush();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule